// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table held in memory. A client presents a translate request made of the virtual address and an access direction (read or write). The walker fetches one directory word, then one leaf word, over a single-word request/response memory port, and finishes with a one-cycle completion pulse carrying the physical address and the leaf's attribute bits, or a fault.

The address splits into a 10-bit directory index (bits 31:22), a 10-bit leaf index (bits 21:12) and a 12-bit page offset (bits 11:0). Pages are 4 KiB, and no large-page entries exist. A fault is raised when an entry lacks its present flag or when the leaf does not grant the requested direction. A memory response flagged as an error ends the walk with a bus-error indication instead. Only one walk runs at a time, and the request-ready output is held low until the walk ends. The directory base address is an input, and it is captured when a request is accepted.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and done_valid is 0.
- R2: The first memory read of a walk is at dir_base + 4 × vaddr[31:22].
- R3: The second read is at (directory word AND 0xFFFFF000) + 4 × vaddr[21:12]. The low 12 bits of the directory word do not affect this address.
- R4: On success done_paddr = {leaf[31:12], vaddr[11:0]} and done_attr = leaf[8:1], with done_fault = 0 and done_bus_err = 0.
- R5: A directory word with bit 0 (present) clear ends the walk with done_fault = 1 after exactly one memory read.
- R6: A leaf word with bit 0 clear ends the walk with done_fault = 1 after two reads.
- R7: A read access needs leaf bit 1, and a write access needs leaf bit 2. When the needed bit is missing, done_fault = 1.
- R8: A response with mem_rsp_err = 1 at either level ends the walk with done_bus_err = 1 and done_fault = 0.
- R9: req_ready stays 0 from acceptance until the completion pulse, and a request presented meanwhile is ignored. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen.
- R10: done_valid lasts exactly one cycle. On every completion, done_vaddr and done_write report the accepted request's address and direction, and req_ready is 1 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_base | input | 32 | Directory base address |
| req_valid | input | 1 | Translate request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table word |
| mem_rsp_err | input | 1 | Returned read failed |
| done_valid | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Translated physical address |
| done_attr | output | 8 | Leaf entry bits 8:1 |
| done_fault | output | 1 | Translation fault |
| done_bus_err | output | 1 | Walk ended on a memory error |
| done_vaddr | output | 32 | Virtual address of the finished walk |
| done_write | output | 1 | Direction of the finished walk |

## Verification
A wrong walk state shows at the memory port within a cycle or two. A read is issued at a wrong address, a second read appears after a missing directory entry, or the port goes silent and no completion arrives. Corrupt captured data, such as the address, the direction or the directory word, surfaces at the next completion as a wrong physical address, wrong reported direction or wrong fault class. The directed tests therefore log every memory read address and compare each completion field against values built from the table contents. The tests cover stalled memory, faults at both levels, missing permissions in both directions and errors at both levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_REQ,
      ST_DIR_WAIT,
      ST_LEAF_REQ,
      ST_LEAF_WAIT,
      ST_DONE
   } walk_st_t;

   // entry flag positions
   localparam int PRESENT_POS = 0;
   localparam int RD_POS      = 1;
   localparam int WR_POS      = 2;
   localparam int ATTR_LO     = 1;
   localparam int ATTR_HI     = 8;
   localparam int ATTR_W      = ATTR_HI - ATTR_LO + 1;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W      = 32,
   parameter int DIR_BITS  = 10,
   parameter int TBL_BITS  = 10,
   parameter int OFF_BITS  = 12,
   parameter int ENT_SHIFT = 2
) (
   input  logic [VA_W-1:0] base,
   input  logic [VA_W-1:0] vaddr,
   input  logic [VA_W-1:0] dir_word,
   output logic [VA_W-1:0] dir_addr,
   output logic [VA_W-1:0] leaf_addr
);
   localparam int TBL_LO = OFF_BITS;
   localparam int DIR_LO = OFF_BITS + TBL_BITS;

   logic [DIR_BITS-1:0] dir_idx;
   logic [TBL_BITS-1:0] tbl_idx;
   logic [VA_W-1:0]     leaf_base;
   logic                unused_bits;

   assign dir_idx   = vaddr[DIR_LO +: DIR_BITS];
   assign tbl_idx   = vaddr[TBL_LO +: TBL_BITS];
   assign leaf_base = {dir_word[VA_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
   assign dir_addr  = base + VA_W'({dir_idx, {ENT_SHIFT{1'b0}}});
   assign leaf_addr = leaf_base + VA_W'({tbl_idx, {ENT_SHIFT{1'b0}}});
   assign unused_bits = ^{dir_word[OFF_BITS-1:0], vaddr[OFF_BITS-1:0]};
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check (
   input  logic [2:0] flags,     // present, read, write
   input  logic       is_leaf,
   input  logic       is_write,
   output logic       ok
);
   import ptw_pkg::*;
   logic perm_ok;

   always_comb begin
      if (!is_leaf)      perm_ok = 1'b1;
      else if (is_write) perm_ok = flags[WR_POS];
      else               perm_ok = flags[RD_POS];
      ok = flags[PRESENT_POS] & perm_ok;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int VA_W       = 32,
   parameter int DIR_BITS   = 10,
   parameter int TBL_BITS   = 10,
   parameter int OFF_BITS   = 12,
   parameter int ENT_SHIFT  = 2,
   parameter bit LATCH_BASE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] dir_base,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [VA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [VA_W-1:0] mem_rsp_data,
   input  logic            mem_rsp_err,
   output logic            done_valid,
   output logic [VA_W-1:0] done_paddr,
   output logic [7:0]      done_attr,
   output logic            done_fault,
   output logic            done_bus_err,
   output logic [VA_W-1:0] done_vaddr,
   output logic            done_write
);
   import ptw_pkg::*;

   localparam int PG_BITS = VA_W - OFF_BITS;

   if (DIR_BITS + TBL_BITS + OFF_BITS != VA_W) begin : g_split_bad
      $error("address split does not cover VA_W");
   end
   if (OFF_BITS <= ATTR_HI) begin : g_off_bad
      $error("page offset too narrow for attribute field");
   end

   walk_st_t        state;
   logic [VA_W-1:0] va_q, dir_word_q, base_use, dir_addr, leaf_addr, paddr_q;
   logic            wr_q, fault_q, berr_q, entry_ok, accept;
   logic [ATTR_W-1:0] attr_q;

   assign accept = (state == ST_IDLE) && req_valid;

   if (LATCH_BASE) begin : g_base_latch
      logic [VA_W-1:0] base_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      base_q <= '0;
         else if (accept) base_q <= dir_base;
      end
      assign base_use = base_q;
   end else begin : g_base_live
      assign base_use = dir_base;
   end

   ptw_addr_gen #(
      .VA_W(VA_W), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS),
      .OFF_BITS(OFF_BITS), .ENT_SHIFT(ENT_SHIFT)
   ) u_addr (
      .base(base_use), .vaddr(va_q), .dir_word(dir_word_q),
      .dir_addr(dir_addr), .leaf_addr(leaf_addr)
   );

   ptw_entry_check u_chk (
      .flags(mem_rsp_data[2:0]),
      .is_leaf(state == ST_LEAF_WAIT),
      .is_write(wr_q),
      .ok(entry_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         dir_word_q <= '0;
         paddr_q    <= '0;
         attr_q     <= '0;
         fault_q    <= 1'b0;
         berr_q     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               paddr_q <= '0;
               attr_q  <= '0;
               fault_q <= 1'b0;
               berr_q  <= 1'b0;
               state   <= ST_DIR_REQ;
            end
            ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  berr_q <= 1'b1;
                  state  <= ST_DONE;
               end else if (!entry_ok) begin
                  fault_q <= 1'b1;
                  state   <= ST_DONE;
               end else begin
                  dir_word_q <= mem_rsp_data;
                  state      <= ST_LEAF_REQ;
               end
            end
            ST_LEAF_REQ: if (mem_req_ready) state <= ST_LEAF_WAIT;
            ST_LEAF_WAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  berr_q <= 1'b1;
               end else if (!entry_ok) begin
                  fault_q <= 1'b1;
               end else begin
                  paddr_q <= {mem_rsp_data[VA_W-1 -: PG_BITS], va_q[OFF_BITS-1:0]};
                  attr_q  <= mem_rsp_data[ATTR_HI:ATTR_LO];
               end
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_DIR_REQ) || (state == ST_LEAF_REQ);
   assign mem_req_addr  = (state == ST_LEAF_REQ) ? leaf_addr : dir_addr;
   assign done_valid    = (state == ST_DONE);
   assign done_paddr    = paddr_q;
   assign done_attr     = attr_q;
   assign done_fault    = fault_q;
   assign done_bus_err  = berr_q;
   assign done_vaddr    = va_q;
   assign done_write    = wr_q;

   // R1
   reset_ready_chk: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !mem_req_valid && !done_valid);

   // R9
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R5
   dir_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DIR_WAIT) && mem_rsp_valid && !mem_rsp_err && !mem_rsp_data[0]
      |=> done_valid && done_fault);

   // R8
   class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !(done_fault && done_bus_err));

   // R10
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid && req_ready);
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] dir_base = 32'h1000_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        done_valid, done_fault, done_bus_err, done_write;
   logic [31:0] done_paddr, done_vaddr;
   logic [7:0]  done_attr;

   int total = 0;
   int fails = 0;

   logic [31:0] mem_q [logic [31:0]];
   logic [31:0] rd_log [64];
   int          rd_cnt = 0;
   logic        slow_mode = 1'b0;
   logic        err_on = 1'b0;
   logic [31:0] err_addr = '0;
   logic [31:0] cyc = '0;

   always #10 clk = ~clk;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .done_valid(done_valid), .done_paddr(done_paddr), .done_attr(done_attr),
      .done_fault(done_fault), .done_bus_err(done_bus_err),
      .done_vaddr(done_vaddr), .done_write(done_write)
   );

   assign mem_req_ready = slow_mode ? cyc[0] : 1'b1;

   always @(posedge clk) begin
      cyc           <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem_q.exists(mem_req_addr) ? mem_q[mem_req_addr] : 32'h0;
         mem_rsp_err   <= err_on && (mem_req_addr == err_addr);
         rd_log[rd_cnt % 64] <= mem_req_addr;
         rd_cnt        <= rd_cnt + 1;
      end
   end

   // captured results of the last walk
   logic [31:0] g_paddr, g_vaddr;
   logic [7:0]  g_attr;
   logic        g_fault, g_berr, g_write, g_busy_bad;
   int          g_reads, g_first;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] e_dir(logic [31:0] va);
      return dir_base + {20'h0, va[31:22], 2'b00};
   endfunction
   function automatic logic [31:0] e_leaf(logic [31:0] dw, logic [31:0] va);
      return (dw & 32'hFFFF_F000) + {20'h0, va[21:12], 2'b00};
   endfunction

   task automatic walk(logic [31:0] va, logic wr, bit junk);
      int n = 0;
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      g_first = rd_cnt;
      @(negedge clk);
      if (junk) begin req_vaddr = ~va; req_write = ~wr; end
      else req_valid = 1'b0;
      g_busy_bad = 1'b0;
      while (!done_valid && n < 1000) begin
         if (req_ready) g_busy_bad = 1'b1;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      if (n >= 1000) begin
         total++; fails++;
         $display("FAIL R10 walk timeout actual=%0d expected<1000", n);
      end
      g_paddr = done_paddr; g_vaddr = done_vaddr; g_attr = done_attr;
      g_fault = done_fault; g_berr = done_bus_err; g_write = done_write;
      @(negedge clk);
      check("R10 done pulse single", {31'h0, done_valid}, 32'h0);
      check("R10 ready after done", {31'h0, req_ready}, 32'h1);
      g_reads = rd_cnt - g_first;
   endtask

   task automatic t_reset;
      check("R1 req_ready", {31'h0, req_ready}, 32'h1);
      check("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
      check("R1 done_valid", {31'h0, done_valid}, 32'h0);
   endtask

   task automatic t_read_ok;
      logic [31:0] va = 32'h0040_3ABC;
      walk(va, 1'b0, 0);
      check("R2 dir addr", rd_log[g_first % 64], e_dir(va));
      check("R3 leaf addr masked", rd_log[(g_first + 1) % 64], e_leaf(32'h2000_0F01, va));
      check("R4 paddr", g_paddr, 32'h3456_7ABC);
      check("R4 attr", {24'h0, g_attr}, 32'h51);
      check("R4 no fault", {30'h0, g_fault, g_berr}, 32'h0);
      check("R10 vaddr", g_vaddr, va);
   endtask

   task automatic t_write_denied;
      walk(32'h0040_3ABC, 1'b1, 0);
      check("R7 write w/o perm faults", {31'h0, g_fault}, 32'h1);
      check("R10 write reported", {31'h0, g_write}, 32'h1);
      check("R7 fault vaddr", g_vaddr, 32'h0040_3ABC);
   endtask

   task automatic t_write_slow;
      logic [31:0] va = 32'hFFC0_1004;
      slow_mode = 1'b1;
      walk(va, 1'b1, 0);
      slow_mode = 1'b0;
      check("R2 dir addr top index", rd_log[g_first % 64], e_dir(va));
      check("R3 leaf addr", rd_log[(g_first + 1) % 64], e_leaf(32'h2100_0001, va));
      check("R4 paddr slow", g_paddr, 32'h0ABC_D004);
      check("R4 attr slow", {24'h0, g_attr}, 32'hFB);
      check("R4 no fault slow", {30'h0, g_fault, g_berr}, 32'h0);
   endtask

   task automatic t_dir_absent;
      walk(32'h0080_0123, 1'b0, 0);
      check("R5 fault", {31'h0, g_fault}, 32'h1);
      check("R5 one read", g_reads, 1);
      check("R5 fault vaddr", g_vaddr, 32'h0080_0123);
   endtask

   task automatic t_leaf_absent;
      walk(32'h0040_5000, 1'b1, 0);
      check("R6 fault", {31'h0, g_fault}, 32'h1);
      check("R6 two reads", g_reads, 2);
      check("R6 write reported", {31'h0, g_write}, 32'h1);
   endtask

   task automatic t_read_denied;
      walk(32'h0040_6010, 1'b0, 0);
      check("R7 read w/o perm faults", {31'h0, g_fault}, 32'h1);
      walk(32'h0040_6010, 1'b1, 0);
      check("R7 write with perm ok", {31'h0, g_fault}, 32'h0);
      check("R7 write paddr", g_paddr, 32'h5555_5010);
      check("R4 attr write-only", {24'h0, g_attr}, 32'h02);
   endtask

   task automatic t_bus_err;
      err_on = 1'b1;
      err_addr = e_dir(32'h00C0_0000);
      walk(32'h00C0_0000, 1'b0, 0);
      check("R8 dir bus err", {30'h0, g_fault, g_berr}, 32'h1);
      check("R8 dir err one read", g_reads, 1);
      err_addr = e_leaf(32'h2000_0F01, 32'h0040_3ABC);
      walk(32'h0040_3ABC, 1'b0, 0);
      check("R8 leaf bus err", {30'h0, g_fault, g_berr}, 32'h1);
      check("R8 leaf err paddr zero", g_paddr, 32'h0);
      err_on = 1'b0;
   endtask

   task automatic t_busy_ignore;
      logic [31:0] va = 32'h0040_3ABC;
      walk(va, 1'b0, 1);
      check("R9 ready low while busy", {31'h0, g_busy_bad}, 32'h0);
      check("R9 junk ignored paddr", g_paddr, 32'h3456_7ABC);
      check("R9 junk ignored vaddr", g_vaddr, va);
      check("R9 junk ignored dir addr", rd_log[g_first % 64], e_dir(va));
      check("R9 two reads only", g_reads, 2);
   endtask

   initial begin
      mem_q[32'h1000_0004] = 32'h2000_0F01;   // dir idx 1
      mem_q[32'h2000_000C] = 32'h3456_70A3;   // leaf idx 3: present, read
      mem_q[32'h1000_0FFC] = 32'h2100_0001;   // dir idx 0x3FF
      mem_q[32'h2100_0004] = 32'h0ABC_D1F7;   // present, read, write
      mem_q[32'h1000_000C] = 32'h2200_0001;   // dir idx 3
      mem_q[32'h2000_0018] = 32'h5555_5005;   // leaf idx 6: present, write only
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_ok();
      t_write_denied();
      t_write_slow();
      t_dir_absent();
      t_leaf_absent();
      t_read_denied();
      t_bus_err();
      t_busy_ignore();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule